// File: doc/BRIEF.md
# Vectored Interrupt Controller with Non-Maskable Channel

This block collects 32 level-sensitive interrupt lines and presents two requests to a processor core. The first is a maskable request carrying an 8-bit vector. The second is a separate non-maskable request. Lines 1 to 29 are ordinary sources, and each one is mirrored into a raw pending bit. Lines 30 and 31 feed a non-maskable status word instead. Line 0 has no effect.

Software enables sources through a mask word. When exactly one enabled source is pending, the vector names it directly. When more than one is pending, the block reports one shared vector, and software reads the pending words to decide which source to serve. There is no priority logic in hardware.

The register window holds five 32-bit words at byte addresses 0x00 to 0x10. Only aligned full-word writes to the mask word take effect. Every input passes through a two-flop synchronizer before it is captured.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, all five register words read zero, `irq_o` and `nmi_o` are low and `vector_o` is 0.
- R2: The mask word at byte address 0x00 is read/write. A write takes effect only when `we_i` is high, the address is 0x00 and `be_i` is 4'hF.
- R3: Each of these writes leaves the mask word unchanged: a write to 0x04, 0x08, 0x0C or 0x10, a write to an unaligned address, and a write with `be_i` other than 4'hF.
- R4: The raw pending word at 0x04 follows the input lines as follows. Bit n-1 follows the level of line n for n = 1..29. Line 0 has no effect. Bits 29 to 31 read zero.
- R5: The masked pending word at 0x08 always reads as the bitwise AND of the raw pending word and the mask word.
- R6: When exactly one masked pending bit i is set, `vector_o` is 0x31 + i and `irq_o` is high.
- R7: When two or more masked pending bits are set, `vector_o` is 0x30 and `irq_o` is high.
- R8: When no masked pending bit is set, `vector_o` is 0 and `irq_o` is low.
- R9: Lines 30 and 31 set and clear bits 30 and 31 of the status word at 0x0C. They never appear in the raw pending word. `nmi_o` is high whenever that status word is nonzero, and the mask has no effect on it.
- R10: Reads of the reserved word at 0x10, of unaligned addresses and of addresses above 0x10 return zero.
- R11: A line change reaches the pending and status words at the third rising clock edge after it. `vector_o` and `irq_o` follow one edge after a change of the pending word or of the mask word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write enable, 1 = write |
| addr_i | input | 5 | Byte address |
| be_i | input | 4 | Byte enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from address |
| lines_i | input | 32 | Level-sensitive interrupt lines |
| irq_o | output | 1 | Maskable interrupt request |
| vector_o | output | 8 | Interrupt vector |
| nmi_o | output | 1 | Non-maskable interrupt request |

## Verification
The hardest state to reach is a mixture of sources in which only the mask separates the single-source vector from the shared vector. An example is two raised lines where exactly one is enabled, followed by a mask write that enables the second. The bench sweeps every line alone and every adjacent pair. It then holds a fixed pair of lines while walking single-bit and two-bit masks, so that the vector changes solely because of mask writes. It also samples the exact edge at which the vector follows the mask.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned VEC_W  = 8;

  typedef enum logic [2:0] {
    OFS_MASK   = 3'd0,
    OFS_RAW    = 3'd1,
    OFS_MASKED = 3'd2,
    OFS_NMI    = 3'd3,
    OFS_RSVD   = 3'd4
  } reg_ofs_e;
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned NMI_LO  = 30
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [BE_W-1:0]    be_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  input  logic [N_LINES-1:0] sync_i,
  output logic [N_LINES-1:0] masked_o,
  output logic [N_LINES-1:0] nmi_q_o
);
  localparam int unsigned WORD_LSB = $clog2(BE_W);

  logic [N_LINES-1:0] mask_q, raw_q, nmi_q, raw_d, nmi_d;
  logic               aligned, mask_wr;
  logic [ADDR_W-WORD_LSB-1:0] word;
  logic               line0_unused;

  assign line0_unused = sync_i[0];

  // line n lands in pending bit n-1; top lines go to the nmi word at their own position
  for (genvar i = 0; i < N_LINES; i++) begin : g_route
    if (i + 1 < NMI_LO) begin : g_pend
      assign raw_d[i] = sync_i[i+1];
    end else begin : g_nopend
      assign raw_d[i] = 1'b0;
    end
    if (i >= NMI_LO) begin : g_nmi
      assign nmi_d[i] = sync_i[i];
    end else begin : g_nonmi
      assign nmi_d[i] = 1'b0;
    end
  end

  assign aligned = (addr_i[WORD_LSB-1:0] == '0);
  assign word    = addr_i[ADDR_W-1:WORD_LSB];
  assign mask_wr = req_i && we_i && aligned && (be_i == '1)
                   && (word == (ADDR_W-WORD_LSB)'(OFS_MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      raw_q  <= '0;
      nmi_q  <= '0;
    end else begin
      raw_q <= raw_d;
      nmi_q <= nmi_d;
      if (mask_wr) mask_q <= wdata_i[N_LINES-1:0];
    end
  end

  assign masked_o = raw_q & mask_q;
  assign nmi_q_o  = nmi_q;

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      unique case (word)
        (ADDR_W-WORD_LSB)'(OFS_MASK):   rdata_o = DATA_W'(mask_q);
        (ADDR_W-WORD_LSB)'(OFS_RAW):    rdata_o = DATA_W'(raw_q);
        (ADDR_W-WORD_LSB)'(OFS_MASKED): rdata_o = DATA_W'(masked_o);
        (ADDR_W-WORD_LSB)'(OFS_NMI):    rdata_o = DATA_W'(nmi_q);
        default:                        rdata_o = '0;
      endcase
    end
  end

  // R3
  ignored_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !mask_wr) |=> $stable(mask_q));

  // R4
  pend_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i[1] |=> raw_q[0]);

  // R2
  mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_wr |=> (mask_q == $past(wdata_i[N_LINES-1:0])));
endmodule

// File: rtl/vic_encode.sv
module vic_encode
  import vic_pkg::*;
#(
  parameter int unsigned N_LINES  = 32,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h30
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] masked_i,
  output logic [VEC_W-1:0]   vector_o,
  output logic               irq_o
);
  localparam int unsigned IDX_W = $clog2(N_LINES);

  logic [IDX_W-1:0] idx;
  logic             any, multi;
  logic [VEC_W-1:0] vec_d, vector_q;
  logic             irq_q;

  // index is only meaningful when a single bit is set
  always_comb begin
    idx = '0;
    for (int i = 0; i < N_LINES; i++)
      if (masked_i[i]) idx = idx | IDX_W'(i);
  end

  assign any   = |masked_i;
  assign multi = |(masked_i & (masked_i - 1'b1));

  always_comb begin
    if (!any)      vec_d = '0;
    else if (multi) vec_d = VEC_BASE;
    else            vec_d = VEC_BASE + VEC_W'(1) + VEC_W'(idx);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vector_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      vector_q <= vec_d;
      irq_q    <= any;
    end
  end

  assign vector_o = vector_q;
  assign irq_o    = irq_q;

  // R7
  shared_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(masked_i) > 1) |=> (vector_q == VEC_BASE));

  // R6
  single_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(masked_i) |=> (irq_q && vector_q > VEC_BASE));

  // R8
  idle_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_q |-> (vector_q == '0));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned N_LINES  = 32,
  parameter int unsigned NMI_LO   = 30,
  parameter int unsigned SYNC_STG = 2,
  parameter logic [7:0]  VEC_BASE = 8'h30
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [4:0]  addr_i,
  input  logic [3:0]  be_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [31:0] lines_i,
  output logic        irq_o,
  output logic [7:0]  vector_o,
  output logic        nmi_o
);
  logic [N_LINES-1:0] sync_q, masked, nmi_bits;

  vic_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(lines_i[N_LINES-1:0]), .q_o(sync_q)
  );

  vic_regs #(.N_LINES(N_LINES), .NMI_LO(NMI_LO)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .be_i(be_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .sync_i(sync_q), .masked_o(masked), .nmi_q_o(nmi_bits)
  );

  vic_encode #(.N_LINES(N_LINES), .VEC_BASE(VEC_BASE)) u_enc (
    .clk_i(clk_i), .rst_ni(rst_ni), .masked_i(masked),
    .vector_o(vector_o), .irq_o(irq_o)
  );

  assign nmi_o = |nmi_bits;

  // R9
  nmi_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sync_q[N_LINES-1:NMI_LO]) |=> nmi_o);

  // R9
  nmi_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|sync_q[N_LINES-1:NMI_LO]) |=> !nmi_o);
endmodule

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vec_irq_ctrl;
  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0, lines_i = '0, rdata_o;
  logic        irq_o, nmi_o;
  logic [7:0]  vector_o;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vec_irq_ctrl u0 (.*, .clk_i(clk));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d; be_i = be;
    @(negedge clk);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr_i = a; req_i = 1; we_i = 0;
    #1 d = rdata_o;
    req_i = 0;
  endtask

  // expected from requirements
  function automatic logic [31:0] raw_of(logic [31:0] l);
    return {3'b0, l[29:1]};
  endfunction
  function automatic logic [7:0] vec_of(logic [31:0] m);
    if (m == 0) return 8'h00;
    if ($countones(m) > 1) return 8'h30;
    for (int i = 0; i < 32; i++) if (m[i]) return 8'h31 + 8'(i);
    return 8'h00;
  endfunction

  task automatic check_state(string tag, logic [31:0] l, logic [31:0] m);
    logic [31:0] d;
    logic [31:0] mk;
    mk = raw_of(l) & m;
    rd(5'h04, d); chk({tag, " R4 raw"}, d, raw_of(l));
    rd(5'h08, d); chk({tag, " R5 masked"}, d, mk);
    rd(5'h0C, d); chk({tag, " R9 nmi word"}, d, l & 32'hC000_0000);
    chk({tag, " R9 nmi_o"}, 32'(nmi_o), 32'(|l[31:30]));
    chk({tag, " R6/R7 vector"}, 32'(vector_o), 32'(vec_of(mk)));
    chk({tag, " R8 irq"}, 32'(irq_o), 32'(mk != 0));
  endtask

  initial begin
    logic [31:0] d;
    cyc(2); rst_ni = 1; cyc(1);
    // R1 reset state
    for (int a = 0; a <= 16; a += 4) begin rd(5'(a), d); chk("R1 reset reg", d, 0); end
    chk("R1 irq", 32'(irq_o), 0); chk("R1 nmi", 32'(nmi_o), 0); chk("R1 vector", 32'(vector_o), 0);

    // R2 mask read/write patterns
    foreach (wdata_i[i]) begin
      wr(5'h00, 32'h1 << i); rd(5'h00, d); chk("R2 mask walk", d, 32'h1 << i);
    end
    wr(5'h00, 32'hA5C3_0F96); rd(5'h00, d); chk("R2 mask pattern", d, 32'hA5C3_0F96);

    // R3 ignored writes
    for (int a = 4; a <= 16; a += 4) begin
      wr(5'(a), 32'hFFFF_FFFF); rd(5'h00, d); chk("R3 other offset", d, 32'hA5C3_0F96);
      rd(5'(a), d); chk("R3 RO word unchanged", d, 0);
    end
    wr(5'h01, 32'h0); rd(5'h00, d); chk("R3 unaligned", d, 32'hA5C3_0F96);
    for (int b = 0; b < 15; b++) begin
      wr(5'h00, 32'h0, 4'(b)); rd(5'h00, d); chk("R3 partial be", d, 32'hA5C3_0F96);
    end

    // R10 reserved / unaligned / out of range
    rd(5'h10, d); chk("R10 reserved", d, 0);
    rd(5'h02, d); chk("R10 unaligned", d, 0);
    rd(5'h14, d); chk("R10 out of range", d, 0);
    rd(5'h1C, d); chk("R10 out of range", d, 0);

    // R4/R6 single line sweep, all enabled
    wr(5'h00, 32'hFFFF_FFFF);
    for (int n = 0; n < 32; n++) begin
      lines_i = 32'h1 << n; cyc(5);
      check_state("sweep1", lines_i, 32'hFFFF_FFFF);
    end
    // R7 adjacent pairs
    for (int n = 1; n < 29; n++) begin
      lines_i = 32'h3 << n; cyc(5);
      check_state("pair", lines_i, 32'hFFFF_FFFF);
    end
    // R8 mask all off
    lines_i = 32'h3FFF_FFFE; wr(5'h00, 0); cyc(2);
    check_state("mask0", lines_i, 0);

    // mask walk over fixed lines 5 and 17 (bits 4, 16)
    lines_i = (32'h1 << 5) | (32'h1 << 17); cyc(5);
    for (int k = 0; k < 32; k++) begin
      wr(5'h00, 32'h1 << k); cyc(1);
      check_state("R5 maskwalk", lines_i, 32'h1 << k);
    end
    wr(5'h00, 32'h0001_0010); cyc(1);
    check_state("R7 both enabled", lines_i, 32'h0001_0010);

    // R11 mask latency: vector changes exactly one edge after the write edge
    wr(5'h00, 32'h0000_0010);
    chk("R11 vector before", 32'(vector_o), 32'h30);
    cyc(1);
    chk("R11 vector after", 32'(vector_o), 32'h35);

    // R11 line latency
    wr(5'h00, 32'hFFFF_FFFF); lines_i = 0; cyc(5);
    @(negedge clk); lines_i = 32'h1 << 3;
    cyc(2); rd(5'h04, d); chk("R11 raw not yet", d, 0);
    cyc(1); rd(5'h04, d); chk("R11 raw at 3rd edge", d, 32'h4);
    chk("R11 irq not yet", 32'(irq_o), 0);
    cyc(1); chk("R11 irq next edge", 32'(irq_o), 1);
    chk("R11 vector next edge", 32'(vector_o), 32'h33);

    // R9 nmi lines independent of mask, set and clear
    wr(5'h00, 0);
    lines_i = 32'h4000_0000; cyc(5); check_state("R9 line30", lines_i, 0);
    lines_i = 32'hC000_0000; cyc(5); check_state("R9 both", lines_i, 0);
    lines_i = 32'h8000_0000; cyc(5); check_state("R9 line31", lines_i, 0);
    lines_i = 32'h0; cyc(5); check_state("R9 clear", lines_i, 0);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule